// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block converts a 64-bit input virtual address into a 48-bit physical address. It does so by walking a translation table of up to four levels, held in memory, in which every descriptor is 64 bits wide. A request carries the address and a read/write flag. Static configuration supplies two table regions, each with a base, a size field, a granule code, a top-byte-ignore flag and a disable flag. The walker uses the high address bits to pick one region. From that region's granule and size field it derives the starting level and the cleared bits of the initial table base.

It then issues one 8-byte descriptor read per level over a single-beat request/response port. Tables are followed downward until a block or page descriptor ends the walk, or a fault does. Table descriptors carry a write-protect bit that is checked before the walker descends. Leaf descriptors carry their own write-protect bit.

The result is a one-cycle done pulse with a 2-bit fault code: 0 none, 1 translation, 2 permission, 3 walk abort. With it come the output address, a granule mask and a permission pair. A new request is taken only while the walker is idle (`busy` low). Configuration must stay stable during a walk.

Top module: `iommu_walker`

## Requirements
- R1: Region choice. Address bit 55 selects which top-byte-ignore flag applies (bit 55 = 1 uses region 1's flag). The checked bits run from bit 64−size upward, and stop below bit 56 when that flag is set or at bit 63 otherwise. Region 0 is used when its size field is nonzero and the checked bits are all zero. Failing that, region 1 is used when its size field is nonzero and its checked bits are all one.
- R2: A region whose size field is zero covers every address the other region does not. An address that falls between two sized regions ends with fault 1 and no memory read. So does an address whose chosen region has its disable flag set.
- R3: Granule codes 0, 1 and 2 select shifts g of 12, 14 and 16, and code 3 gives fault 1. The input size is 64 − size, and the stride is g − 3. The start level is 4 − (input size − 4)/stride using integer division, floored at 0. An input size below 4, or a start level of 4, gives fault 1 with no memory read.
- R4: The initial base is bits [47:0] of the region base, with its low n bits cleared, where n = input size − stride·(4 − start level). The descriptor address is the base plus 8 × index. The index is bits [g+(3−L)·stride +: stride] of the address, after the address is masked to the input size.
- R5: Each level makes exactly one read. mem_req is a one-cycle pulse carrying an 8-byte-aligned address, and a walk makes at most four reads.
- R6: A response with mem_rerr set ends the walk with fault 3.
- R7: A descriptor with bit 0 clear ends the walk with fault 1. At level 3, a descriptor with bits [1:0] = 01 also ends the walk with fault 1.
- R8: Bits [1:0] = 01 at levels 0–2 mark a block, and bits [1:0] = 11 at level 3 mark a page. In both cases the output address is descriptor bits [47:s] joined with address bits [s−1:0], where s = g + (3−L)·stride.
- R9: A table descriptor (bits [1:0] = 11 at levels 0–2) with bit 62 set ends a write request with fault 2 and makes no further read. When the walker does descend, the next base is descriptor bits [47:g] with the low g bits zero.
- R10: Leaf bit 7 set marks the mapping read-only, and a write request through it ends with fault 2. A successful walk reports res_perm = {~bit7, 1}, where bit 1 is write and bit 0 is read.
- R11: A successful walk reports res_mask = 2^g − 1. A fault reports res_perm, res_mask and res_pa all as zero.
- R12: done is high for exactly one cycle per accepted request. It rises the cycle after the final response, or the cycle after acceptance when the fault is detected at the start. busy is low once done is seen, and req_valid is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tsz0 | input | 6 | Region 0 size field |
| cfg_tsz1 | input | 6 | Region 1 size field |
| cfg_gran0 | input | 2 | Region 0 granule code |
| cfg_gran1 | input | 2 | Region 1 granule code |
| cfg_base0 | input | 64 | Region 0 table base |
| cfg_base1 | input | 64 | Region 1 table base |
| cfg_tbi0 | input | 1 | Region 0 top-byte-ignore flag |
| cfg_tbi1 | input | 1 | Region 1 top-byte-ignore flag |
| cfg_off0 | input | 1 | Region 0 disabled |
| cfg_off1 | input | 1 | Region 1 disabled |
| req_valid | input | 1 | Start a walk (sampled while idle) |
| req_va | input | 64 | Input address |
| req_write | input | 1 | 1 = write access, 0 = read |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 48 | Descriptor address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Descriptor returned |
| mem_rerr | input | 1 | Read response error |
| done | output | 1 | Result valid pulse |
| res_fault | output | 2 | Fault code |
| res_pa | output | 48 | Translated address |
| res_mask | output | 48 | Granule mask |
| res_perm | output | 2 | {write, read} permission |

## Verification
The bench targets the following corner cases:
- Addresses in the gap between two sized regions, where a wrong region decode would start a walk that should never begin.
- Top bytes that are non-canonical under top-byte-ignore, which a design that checks all 64 bits would reject.
- Regions with a zero size field, where a clamped start level and masked index are needed to get the descriptor address right.
- Level-3 descriptors with bits [1:0] = 01, which a design treating them as blocks would translate.
- Write-protect bits at table and leaf levels, where a missed check returns a writable mapping.
- Error responses and out-of-range granule or size values, where a careless design would read memory or hang.

Every descriptor address the walker issues is compared against an independently computed expectation. This exposes off-by-one errors in start level, stride or base masking.

// File: rtl/iommu_walker.sv
module iommu_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cfg_tsz0,
  input  logic [5:0]  cfg_tsz1,
  input  logic [1:0]  cfg_gran0,
  input  logic [1:0]  cfg_gran1,
  input  logic [63:0] cfg_base0,
  input  logic [63:0] cfg_base1,
  input  logic        cfg_tbi0,
  input  logic        cfg_tbi1,
  input  logic        cfg_off0,
  input  logic        cfg_off1,
  input  logic        req_valid,
  input  logic [63:0] req_va,
  input  logic        req_write,
  output logic        busy,
  output logic        mem_req,
  output logic [47:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [63:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        done,
  output logic [1:0]  res_fault,
  output logic [47:0] res_pa,
  output logic [47:0] res_mask,
  output logic [1:0]  res_perm
);
  localparam logic [1:0] F_NONE = 2'd0, F_TRANS = 2'd1, F_PERM = 2'd2, F_ABORT = 2'd3;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;
  st_t st;

  logic [1:0]  lvl;
  logic [47:0] base;
  logic [63:0] va_q;
  logic        wr_q;
  logic [4:0]  gq;
  logic [6:0]  isz_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_base0[63:48], cfg_base1[63:48], mem_rdata[63], mem_rdata[61:48], mem_rdata[6:2]};

  // start-of-walk decode
  logic        tbi, in0, in1, hit, rsel, bad, s_off, sfault;
  logic [63:0] chk0, chk1, imask;
  logic [5:0]  s_tsz;
  logic [1:0]  s_gc;
  logic [47:0] s_base, base0;
  int          top, gs, isz, sl, n;

  always_comb begin
    tbi = req_va[55] ? cfg_tbi1 : cfg_tbi0;
    top = tbi ? 56 : 64;
    for (int i = 0; i < 64; i++) begin
      chk0[i] = (i >= 64 - int'(cfg_tsz0)) && (i < top);
      chk1[i] = (i >= 64 - int'(cfg_tsz1)) && (i < top);
    end
    in0 = (cfg_tsz0 != 6'd0) && ((req_va & chk0) == 64'd0);
    in1 = (cfg_tsz1 != 6'd0) && ((req_va & chk1) == chk1);
    hit  = 1'b1;
    rsel = 1'b0;
    if (in0)                    rsel = 1'b0;
    else if (in1)               rsel = 1'b1;
    else if (cfg_tsz0 == 6'd0)  rsel = 1'b0;
    else if (cfg_tsz1 == 6'd0)  rsel = 1'b1;
    else                        hit  = 1'b0;
    s_tsz  = rsel ? cfg_tsz1 : cfg_tsz0;
    s_gc   = rsel ? cfg_gran1 : cfg_gran0;
    s_base = rsel ? cfg_base1[47:0] : cfg_base0[47:0];
    s_off  = rsel ? cfg_off1 : cfg_off0;
    case (s_gc)
      2'd0:    gs = 12;
      2'd1:    gs = 14;
      2'd2:    gs = 16;
      default: gs = 0;
    endcase
    isz = 64 - int'(s_tsz);
    bad = (gs == 0) || (isz < 4);
    sl  = bad ? 0 : 4 - (isz - 4) / (gs - 3);
    if (sl < 0) sl = 0;
    if (sl > 3) bad = 1'b1;
    n = isz - (gs - 3) * (4 - sl);
    imask = (n <= 0) ? 64'd0 : ((64'd1 << n) - 64'd1);
    base0 = s_base & ~imask[47:0];
    sfault = !hit || s_off || bad;
  end

  // per-level index and leaf mask
  int          sw, lsh;
  logic [63:0] vam, idx, lm;
  logic [47:0] gmask;

  always_comb begin
    sw    = int'(gq) - 3;
    lsh   = int'(gq) + (3 - int'(lvl)) * sw;
    vam   = (isz_q >= 7'd64) ? '1 : ((64'd1 << isz_q) - 64'd1);
    idx   = ((va_q & vam) >> lsh) & ((64'd1 << sw) - 64'd1);
    lm    = (64'd1 << lsh) - 64'd1;
    gmask = (48'd1 << gq) - 48'd1;
  end

  assign mem_req  = (st == ISSUE);
  assign mem_addr = base + {idx[44:0], 3'b000};
  assign busy     = (st != IDLE);

  // descriptor decode
  logic       leaf;
  logic [1:0] wfault;

  always_comb begin
    leaf = (lvl == 2'd3) || !mem_rdata[1];
    if (mem_rerr)                                        wfault = F_ABORT;
    else if (!mem_rdata[0] || (lvl == 2'd3 && !mem_rdata[1])) wfault = F_TRANS;
    else if (wr_q && (leaf ? mem_rdata[7] : mem_rdata[62]))   wfault = F_PERM;
    else                                                 wfault = F_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; lvl <= 2'd0; base <= '0; va_q <= '0; wr_q <= 1'b0;
      gq <= 5'd12; isz_q <= 7'd48;
      done <= 1'b0; res_fault <= F_NONE; res_pa <= '0; res_mask <= '0; res_perm <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          va_q <= req_va;
          wr_q <= req_write;
          if (sfault) begin
            done <= 1'b1; res_fault <= F_TRANS;
            res_pa <= '0; res_mask <= '0; res_perm <= '0;
          end else begin
            gq <= 5'(gs); isz_q <= 7'(isz); lvl <= 2'(sl); base <= base0;
            st <= ISSUE;
          end
        end
        ISSUE: st <= WAIT;
        WAIT: if (mem_rvalid) begin
          if (wfault != F_NONE || leaf) begin
            st <= IDLE; done <= 1'b1; res_fault <= wfault;
            if (wfault == F_NONE) begin
              res_pa   <= (mem_rdata[47:0] & ~lm[47:0]) | (va_q[47:0] & lm[47:0]);
              res_mask <= gmask;
              res_perm <= {~mem_rdata[7], 1'b1};
            end else begin
              res_pa <= '0; res_mask <= '0; res_perm <= '0;
            end
          end else begin
            base <= mem_rdata[47:0] & ~gmask;
            lvl  <= lvl + 2'd1;
            st   <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[2:0] == 3'd0);
  // R11
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault != F_NONE) |-> (res_perm == 2'b00 && res_mask == 48'd0));
  // R11
  mask_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == F_NONE) |-> (res_mask == 48'hfff || res_mask == 48'h3fff || res_mask == 48'hffff));
  // R10
  write_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == F_NONE && wr_q) |-> res_perm == 2'b11);
endmodule

// File: tb/tb_iommu_walker.sv
module tb_iommu_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [5:0]  cfg_tsz0, cfg_tsz1;
  logic [1:0]  cfg_gran0, cfg_gran1;
  logic [63:0] cfg_base0, cfg_base1;
  logic        cfg_tbi0, cfg_tbi1, cfg_off0, cfg_off1;
  logic        req_valid, req_write;
  logic [63:0] req_va;
  logic        busy, mem_req, mem_rvalid, mem_rerr, done;
  logic [47:0] mem_addr, res_pa, res_mask;
  logic [63:0] mem_rdata;
  logic [1:0]  res_fault, res_perm;

  iommu_walker dut (.*);

  int checks = 0, errors = 0;
  localparam int K_TAB = 0, K_BLK = 1, K_INV = 2, K_RES = 3, K_ERR = 4, K_PAGE = 5;
  int force_k[4];
  int force_b62 = -1, force_b7 = -1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_start(input logic [63:0] va, output int why, output int g,
                             output int isz, output int lvl, output logic [47:0] base);
    bit tbi, z0, o1, off; int top, rs, s, n;
    logic [63:0] tb; logic [5:0] tz; logic [1:0] gc;
    z0 = 1; o1 = 1;
    tbi = va[55] ? cfg_tbi1 : cfg_tbi0;
    top = tbi ? 56 : 64;
    for (int i = 0; i < 64; i++) begin
      if (i >= 64 - int'(cfg_tsz0) && i < top && va[i]) z0 = 0;
      if (i >= 64 - int'(cfg_tsz1) && i < top && !va[i]) o1 = 0;
    end
    if (cfg_tsz0 != 0 && z0) rs = 0;
    else if (cfg_tsz1 != 0 && o1) rs = 1;
    else if (cfg_tsz0 == 0) rs = 0;
    else if (cfg_tsz1 == 0) rs = 1;
    else rs = -1;
    why = 0; g = 0; isz = 0; lvl = 0; base = '0;
    if (rs < 0) begin why = 2; return; end
    tz  = rs ? cfg_tsz1 : cfg_tsz0;
    gc  = rs ? cfg_gran1 : cfg_gran0;
    tb  = rs ? cfg_base1 : cfg_base0;
    off = rs ? cfg_off1 : cfg_off0;
    if (off) begin why = 2; return; end
    g = (gc == 0) ? 12 : (gc == 1) ? 14 : (gc == 2) ? 16 : 0;
    isz = 64 - int'(tz);
    if (g == 0 || isz < 4) begin why = 3; return; end
    s = g - 3;
    lvl = 4 - (isz - 4) / s;
    if (lvl < 0) lvl = 0;
    if (lvl > 3) begin why = 3; return; end
    n = isz - s * (4 - lvl);
    base = tb[47:0];
    if (n > 0) base = base & ~(48'((64'd1 << n) - 64'd1));
  endtask

  task automatic walk(input logic [63:0] va, input bit wr);
    int why, g, isz, lvl, s, lsh, k, r, nreads, cyc;
    logic [47:0] base, epa, emask; logic [1:0] eperm; int efault; string tag;
    logic [63:0] vam, idx, d, lm, ea; bit err, fin;
    model_start(va, why, g, isz, lvl, base);
    fin = (why != 0); efault = fin ? 1 : 0;
    tag = (why == 2) ? "R2" : "R3";
    epa = '0; emask = '0; eperm = '0; nreads = 0; cyc = 0;
    @(negedge clk); req_valid = 1; req_va = va; req_write = wr;
    @(negedge clk); req_valid = 0;
    while (!done && cyc < 400) begin
      cyc++;
      if (mem_req) begin
        nreads++;
        if (fin) begin chk(0, {tag, " read after walk should end"}, 64'(mem_addr), 0); break; end
        s = g - 3; lsh = g + (3 - lvl) * s;
        vam = (isz >= 64) ? '1 : ((64'd1 << isz) - 64'd1);
        idx = ((va & vam) >> lsh) & ((64'd1 << s) - 64'd1);
        ea = 64'(base) + idx * 8;
        chk(mem_addr == ea[47:0], "R1 R4 descriptor address", 64'(mem_addr), 64'(ea[47:0]));
        r = $urandom % 100;
        if (force_k[lvl] >= 0) k = force_k[lvl];
        else if (lvl < 3) k = (r < 6) ? K_INV : (r < 11) ? K_ERR : (r < 35) ? K_BLK : K_TAB;
        else k = (r < 6) ? K_INV : (r < 11) ? K_RES : (r < 16) ? K_ERR : K_PAGE;
        d = {$urandom, $urandom}; err = 0;
        d[62] = (force_b62 >= 0) ? force_b62[0] : ($urandom % 5 == 0);
        d[7]  = (force_b7 >= 0) ? force_b7[0] : ($urandom % 3 == 0);
        case (k)
          K_TAB, K_PAGE: d[1:0] = 2'b11;
          K_BLK, K_RES:  d[1:0] = 2'b01;
          K_INV:         d[0] = 1'b0;
          default:       err = 1;
        endcase
        if (err) begin fin = 1; efault = 3; tag = "R6"; end
        else if (k == K_INV || k == K_RES) begin fin = 1; efault = 1; tag = "R7"; end
        else if (k == K_BLK || k == K_PAGE) begin
          fin = 1;
          if (wr && d[7]) begin efault = 2; tag = "R10"; end
          else begin
            lm = (64'd1 << lsh) - 64'd1;
            ea = (d & ~lm) | (va & lm);
            epa = ea[47:0]; eperm = {~d[7], 1'b1};
            emask = 48'((64'd1 << g) - 64'd1); efault = 0; tag = "R8";
          end
        end else begin
          if (wr && d[62]) begin fin = 1; efault = 2; tag = "R9"; end
          else begin base = d[47:0] & ~(48'((64'd1 << g) - 64'd1)); lvl++; end
        end
        repeat ($urandom % 3) begin
          @(negedge clk);
          req_valid = ($urandom % 4 == 0); req_va = ~va;
        end
        @(negedge clk); req_valid = 0; mem_rvalid = 1; mem_rdata = d; mem_rerr = err;
        @(negedge clk); mem_rvalid = 0; mem_rerr = 0;
      end else @(negedge clk);
    end
    chk(done == 1'b1, "R12 done seen", 64'(done), 1);
    chk(res_fault == 2'(efault), {tag, " fault code"}, 64'(res_fault), 64'(efault));
    chk(res_perm == eperm, efault != 0 ? "R11 perm on fault" : "R10 perm", 64'(res_perm), 64'(eperm));
    chk(res_mask == emask, "R11 mask", 64'(res_mask), 64'(emask));
    chk(res_pa == epa, efault != 0 ? "R11 pa on fault" : "R8 output address", 64'(res_pa), 64'(epa));
    chk(nreads <= 4, "R5 read count", 64'(nreads), 4);
    @(negedge clk);
    chk(!done && !busy && !mem_req, "R12 single pulse then idle", {61'd0, done, busy, mem_req}, 0);
    for (int i = 0; i < 4; i++) force_k[i] = -1;
    force_b62 = -1; force_b7 = -1;
  endtask

  task automatic base_cfg();
    cfg_tsz0 = 6'd16; cfg_tsz1 = 6'd16; cfg_gran0 = 2'd0; cfg_gran1 = 2'd0;
    cfg_base0 = 64'h0000_0012_3456_7000; cfg_base1 = 64'hffff_00ab_cdef_1000;
    cfg_tbi0 = 0; cfg_tbi1 = 0; cfg_off0 = 0; cfg_off1 = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) force_k[i] = -1;
    base_cfg();
    rst_n = 0; req_valid = 0; req_va = '0; req_write = 0;
    mem_rvalid = 0; mem_rdata = '0; mem_rerr = 0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !busy, "R12 reset state", {61'd0, done, mem_req, busy}, 0);
    chk(res_fault == 0 && res_perm == 0, "R11 reset result", {60'd0, res_fault, res_perm}, 0);
    rst_n = 1; @(negedge clk);

    // R2: gap between two sized regions
    base_cfg(); cfg_tsz0 = 25; cfg_tsz1 = 25;
    walk(64'h0001_0000_0000_0000, 0);
    // R2: disabled region
    base_cfg(); cfg_off0 = 1;
    walk(64'h0000_0000_1234_5000, 0);
    // R2: zero-size region covers the rest, full walk to a page
    base_cfg(); cfg_tsz0 = 0; cfg_tsz1 = 25;
    force_k = '{K_TAB, K_TAB, K_TAB, K_PAGE}; force_b62 = 0; force_b7 = 0;
    walk(64'h0000_7654_3210_8abc, 1);
    // R1: top byte ignored under the flag
    base_cfg(); cfg_tbi0 = 1;
    force_k = '{K_TAB, K_TAB, K_TAB, K_PAGE}; force_b7 = 1;
    walk(64'hab00_0000_1234_5678, 0);
    // R1: region 1 via all-ones
    base_cfg(); cfg_gran1 = 2'd1;
    force_k = '{K_TAB, K_TAB, K_TAB, K_PAGE}; force_b62 = 0; force_b7 = 0;
    walk(64'hffff_8000_0abc_d123, 1);
    // R3: granule code 3 and too-small input size
    base_cfg(); cfg_gran0 = 2'd3;
    walk(64'h0000_0000_0000_1000, 0);
    base_cfg(); cfg_tsz0 = 62;
    walk(64'h0000_0000_0000_0001, 0);
    // R6: error at the first level
    base_cfg(); force_k[0] = K_ERR;
    walk(64'h0000_1111_2222_3000, 0);
    // R7: reserved at level 3
    base_cfg(); force_k = '{K_TAB, K_TAB, K_TAB, K_RES};
    walk(64'h0000_0000_4444_5000, 0);
    // R9: write blocked by a table
    base_cfg(); force_k[0] = K_TAB; force_b62 = 1;
    walk(64'h0000_0000_4444_5000, 1);
    // R8: 64K granule block at the start level
    base_cfg(); cfg_gran0 = 2'd2; force_k[1] = K_BLK; force_b7 = 0;
    walk(64'h0000_1234_5678_9abc, 0);
    // R10: read-only leaf on a write
    base_cfg(); force_k = '{K_TAB, K_TAB, K_BLK, K_PAGE}; force_b62 = 0; force_b7 = 1;
    walk(64'h0000_0000_7777_8000, 1);

    for (int t = 0; t < 300; t++) begin
      logic [63:0] va; int m;
      cfg_tsz0 = ($urandom % 8 == 0) ? 6'd0 : 6'(16 + $urandom % 24);
      cfg_tsz1 = ($urandom % 8 == 0) ? 6'd0 : 6'(16 + $urandom % 24);
      cfg_gran0 = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      cfg_gran1 = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      cfg_base0 = {$urandom, $urandom}; cfg_base1 = {$urandom, $urandom};
      cfg_tbi0 = $urandom % 2; cfg_tbi1 = $urandom % 2;
      cfg_off0 = ($urandom % 16 == 0); cfg_off1 = ($urandom % 16 == 0);
      m = $urandom % 3;
      va = {$urandom, $urandom};
      if (m == 0) va[63:48] = 16'h0000;
      else if (m == 1) va[63:48] = 16'hffff;
      if ($urandom % 2 == 1) va[63:56] = 8'($urandom);
      walk(va, $urandom % 2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule